// File: doc/BRIEF.md
# Operand Cache Line Maintenance Controller

This block carries out line maintenance on a 4-way set-associative operand cache of 256 sets per way with 32-byte lines. It holds the tag, valid and dirty bits and the line data. A caller issues one of four commands with a 32-bit address: invalidate, purge, write-back, or a coherency flush. The first three act on the array by index when the top address byte selects the array window. The flush looks the address up by physical tag. Dirty data leaves through a request/acknowledge write-back port. The port may take any number of cycles to answer.

The surrounding load/store and refill pipeline installs lines through a fill port. That port is the only way lines enter the cache. Only one command runs at a time. `busy_o` holds off new commands, and `done_o` marks completion. An indexed command from user mode completes with `addr_err_o` instead of acting.

Top module: `ocache_maint`

## Requirements
- R1: After reset every line is invalid and clean, and `busy_o`, `done_o`, `addr_err_o` and `wb_req_o` are low.
- R2: `cmd_op_i` encodes 0 invalidate, 1 purge, 2 write-back, 3 flush. A command is taken when `cmd_valid_i` is high and `busy_o` is low. From the next cycle `busy_o` stays high through a single-cycle `done_o` pulse and then falls. A `cmd_valid_i` seen while `busy_o` is high is ignored.
- R3: An indexed command (op 0 to 2) whose address bits [31:24] equal 0xF4 selects way bits [14:13] and set bits [12:5] with no tag compare.
- R4: Indexed invalidate clears the line's valid and dirty bits and never writes back, even a dirty line.
- R5: Indexed purge of a valid dirty line writes it back, then invalidates it. A clean or invalid line is invalidated without a write-back.
- R6: Indexed write-back of a valid dirty line writes it back and clears dirty, and the line stays valid. Otherwise nothing happens.
- R7: An indexed command in the 0xF4 window with `cmd_priv_i` low completes with `addr_err_o` high during the `done_o` cycle. It performs no write-back and changes no state. No other exception output exists.
- R8: An indexed command whose bits [31:24] are not 0xF4 completes with no error, no write-back and no state change, in either privilege mode.
- R9: Flush uses set bits [12:5] and compares tag bits [31:13] against every valid way. On a hit to a dirty line it writes the line back and clears dirty, and the line stays valid. A miss or a clean hit completes with no effect. Flush is not privilege-checked and never errors.
- R10: A write-back presents `wb_addr_o` = {stored tag, set, 5'b0} and the full 256-bit line on `wb_data_o`. It holds `wb_req_o` and both values stable until `wb_ack_i`. It applies the state change at the acknowledge edge, and `done_o` follows in the next cycle.
- R11: A fill with `fill_valid_i` high while `busy_o` is low installs the tag, data and dirty bit and marks the line valid. A fill while `busy_o` is high is ignored.
- R12: A fill and a command accepted in the same cycle are both taken, and the command acts on the freshly installed line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command issue strobe |
| cmd_op_i | input | 2 | Command code |
| cmd_addr_i | input | 32 | Command address operand |
| cmd_priv_i | input | 1 | High when the issuer is privileged |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Single-cycle completion pulse |
| addr_err_o | output | 1 | Address-error exception, valid with done_o |
| fill_valid_i | input | 1 | Install a line |
| fill_way_i | input | 2 | Way to install |
| fill_set_i | input | 8 | Set to install |
| fill_tag_i | input | 19 | Physical tag of the installed line |
| fill_dirty_i | input | 1 | Dirty bit of the installed line |
| fill_data_i | input | 256 | Line data |
| wb_req_o | output | 1 | Write-back request |
| wb_addr_o | output | 32 | Line-aligned write-back address |
| wb_data_o | output | 256 | Write-back line data |
| wb_ack_i | input | 1 | Write-back acknowledge |

## Verification
Two things can happen in the same cycle: a fill on the install port, and the acceptance of a maintenance command aimed at the line being filled. The bench drives both on one edge, once with an indexed write-back and once with a flush by tag. It passes only if the write-back carries the new tag and data. While a write-back waits for its acknowledge, the bench also drives a fill and a second command. It then shows that neither took effect: a later indexed write-back of the filled line finds nothing, and a later flush still finds the dirty line.

// File: rtl/ocache_pkg.sv
package ocache_pkg;
  typedef enum logic [1:0] {
    OP_INV   = 2'd0,
    OP_PURGE = 2'd1,
    OP_WB    = 2'd2,
    OP_FLUSH = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_DONE
  } st_e;

  localparam logic [7:0] ARRAY_WIN = 8'hF4;
endpackage

// File: rtl/ocache_decode.sv
module ocache_decode
  import ocache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WAY_W  = 2,
  parameter int SET_W  = 8,
  parameter int OFF_W  = 5,
  localparam int TAG_W = ADDR_W - SET_W - OFF_W
) (
  input  op_e                     op_i,
  input  logic [ADDR_W-1:OFF_W]   adr_i,
  input  logic                    priv_i,
  output logic                    win_o,
  output logic                    err_o,
  output logic [WAY_W-1:0]        way_o,
  output logic [SET_W-1:0]        set_o,
  output logic [TAG_W-1:0]        tag_o
);
  assign win_o = (adr_i[ADDR_W-1 -: 8] == ARRAY_WIN);
  assign err_o = win_o && !priv_i && (op_i != OP_FLUSH);
  assign way_o = adr_i[OFF_W+SET_W +: WAY_W];
  assign set_o = adr_i[OFF_W +: SET_W];
  assign tag_o = adr_i[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/ocache_tag_store.sv
module ocache_tag_store #(
  parameter int WAYS  = 4,
  parameter int SETS  = 256,
  parameter int TAG_W = 19,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        fill_we_i,
  input  logic [WAY_W-1:0]            fill_way_i,
  input  logic [SET_W-1:0]            fill_set_i,
  input  logic [TAG_W-1:0]            fill_tag_i,
  input  logic                        fill_dirty_i,
  input  logic                        upd_we_i,
  input  logic [WAY_W-1:0]            upd_way_i,
  input  logic [SET_W-1:0]            upd_set_i,
  input  logic                        upd_valid_i,
  input  logic                        upd_dirty_i,
  input  logic [SET_W-1:0]            rd_set_i,
  input  logic [TAG_W-1:0]            cmp_tag_i,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag_o,
  output logic [WAYS-1:0]             rd_valid_o,
  output logic [WAYS-1:0]             rd_dirty_o,
  output logic [WAYS-1:0]             hit_o
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [TAG_W-1:0] tag_q   [WAYS][SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      if (fill_we_i) begin
        valid_q[fill_set_i][fill_way_i] <= 1'b1;
        dirty_q[fill_set_i][fill_way_i] <= fill_dirty_i;
      end
      if (upd_we_i) begin
        valid_q[upd_set_i][upd_way_i] <= upd_valid_i;
        dirty_q[upd_set_i][upd_way_i] <= upd_dirty_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_we_i) tag_q[fill_way_i][fill_set_i] <= fill_tag_i;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign rd_tag_o[w]   = tag_q[w][rd_set_i];
    assign rd_valid_o[w] = valid_q[rd_set_i][w];
    assign rd_dirty_o[w] = dirty_q[rd_set_i][w];
    assign hit_o[w]      = valid_q[rd_set_i][w] && (tag_q[w][rd_set_i] == cmp_tag_i);
  end

  AST_ONE_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_we_i && upd_we_i)); // R11
endmodule

// File: rtl/ocache_data_store.sv
module ocache_data_store #(
  parameter int WAYS   = 4,
  parameter int SETS   = 256,
  parameter int LINE_W = 256,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS),
  localparam int DEPTH = WAYS * SETS
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [SET_W-1:0]  wr_set_i,
  input  logic [LINE_W-1:0] wr_data_i,
  input  logic [WAY_W-1:0]  rd_way_i,
  input  logic [SET_W-1:0]  rd_set_i,
  output logic [LINE_W-1:0] rd_data_o
);
  logic [LINE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[{wr_way_i, wr_set_i}] <= wr_data_i;
  end

  assign rd_data_o = mem_q[{rd_way_i, rd_set_i}];
endmodule

// File: rtl/ocache_ctrl.sv
module ocache_ctrl
  import ocache_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SET_W = 8,
  parameter int TAG_W = 19,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_fire_i,
  input  op_e               op_i,
  input  logic              dec_win_i,
  input  logic              dec_err_i,
  input  logic [WAY_W-1:0]  dec_way_i,
  input  logic [SET_W-1:0]  dec_set_i,
  input  logic [TAG_W-1:0]  dec_tag_i,
  input  logic [WAYS-1:0]   lk_valid_i,
  input  logic [WAYS-1:0]   lk_dirty_i,
  input  logic [WAYS-1:0]   lk_hit_i,
  input  logic              wb_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              wb_req_o,
  output logic [SET_W-1:0]  set_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [WAY_W-1:0]  wb_way_o,
  output logic              upd_we_o,
  output logic [WAY_W-1:0]  upd_way_o,
  output logic              upd_valid_o,
  output logic              upd_dirty_o
);
  st_e               state_q;
  op_e               op_q;
  logic              win_q, err_q;
  logic [WAY_W-1:0]  way_q, wb_way_q;
  logic [SET_W-1:0]  set_q;
  logic [TAG_W-1:0]  tag_q;

  logic              is_flush, any_hit, need_wb, skip;
  logic [WAY_W-1:0]  hit_way, tgt_way;

  assign is_flush = (op_q == OP_FLUSH);
  assign any_hit  = |lk_hit_i;

  // lowest hitting way wins
  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (lk_hit_i[w]) hit_way = WAY_W'(w);
    end
  end

  assign tgt_way = is_flush ? hit_way : way_q;
  assign skip    = !is_flush && (!win_q || err_q);
  assign need_wb = is_flush ? (any_hit && lk_dirty_i[tgt_way])
                            : ((op_q != OP_INV) && lk_valid_i[tgt_way] && lk_dirty_i[tgt_way]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_INV;
      win_q    <= 1'b0;
      err_q    <= 1'b0;
      way_q    <= '0;
      wb_way_q <= '0;
      set_q    <= '0;
      tag_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_fire_i) begin
          op_q    <= op_i;
          win_q   <= dec_win_i;
          err_q   <= dec_err_i;
          way_q   <= dec_way_i;
          set_q   <= dec_set_i;
          tag_q   <= dec_tag_i;
          state_q <= ST_LOOK;
        end
        ST_LOOK: begin
          if (!skip && need_wb) begin
            wb_way_q <= tgt_way;
            state_q  <= ST_WB;
          end else begin
            state_q  <= ST_DONE;
          end
        end
        ST_WB:   if (wb_ack_i) state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    upd_we_o    = 1'b0;
    upd_way_o   = tgt_way;
    upd_valid_o = 1'b0;
    upd_dirty_o = 1'b0;
    if (state_q == ST_LOOK && !skip && !need_wb && !is_flush && op_q != OP_WB) begin
      upd_we_o = 1'b1;
    end else if (state_q == ST_WB && wb_ack_i) begin
      upd_we_o    = 1'b1;
      upd_way_o   = wb_way_q;
      upd_valid_o = (op_q != OP_PURGE);
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_DONE);
  assign err_o    = done_o && err_q;
  assign wb_req_o = (state_q == ST_WB);
  assign set_o    = set_q;
  assign tag_o    = tag_q;
  assign wb_way_o = wb_way_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2
  AST_BUSY_TO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o)); // R2
  AST_INV_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o |-> (op_q != OP_INV)); // R4
  AST_ERR_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !$past(wb_req_o)); // R7
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_req_o && !wb_ack_i) |=> wb_req_o); // R10
  AST_NO_EARLY_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_req_o && !wb_ack_i) |-> !upd_we_o); // R10
endmodule

// File: rtl/ocache_maint.sv
module ocache_maint
  import ocache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 4,
  parameter int SETS   = 256,
  parameter int LINE_B = 32,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int SET_W  = $clog2(SETS),
  localparam int OFF_W  = $clog2(LINE_B),
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W,
  localparam int LINE_W = LINE_B * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              cmd_priv_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              addr_err_o,
  input  logic              fill_valid_i,
  input  logic [WAY_W-1:0]  fill_way_i,
  input  logic [SET_W-1:0]  fill_set_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic              fill_dirty_i,
  input  logic [LINE_W-1:0] fill_data_i,
  output logic              wb_req_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [LINE_W-1:0] wb_data_o,
  input  logic              wb_ack_i
);
  logic                       cmd_fire, fill_we;
  logic                       dec_win, dec_err;
  logic [WAY_W-1:0]           dec_way, wb_way, upd_way;
  logic [SET_W-1:0]           dec_set, cur_set;
  logic [TAG_W-1:0]           dec_tag, cur_tag;
  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [WAYS-1:0]            rd_valid, rd_dirty, hit;
  logic                       upd_we, upd_valid, upd_dirty;
  logic                       unused_lo;

  assign unused_lo = ^cmd_addr_i[OFF_W-1:0];
  assign cmd_fire  = cmd_valid_i && !busy_o;
  assign fill_we   = fill_valid_i && !busy_o;

  ocache_decode #(
    .ADDR_W(ADDR_W), .WAY_W(WAY_W), .SET_W(SET_W), .OFF_W(OFF_W)
  ) u_dec (
    .op_i   (op_e'(cmd_op_i)),
    .adr_i  (cmd_addr_i[ADDR_W-1:OFF_W]),
    .priv_i (cmd_priv_i),
    .win_o  (dec_win),
    .err_o  (dec_err),
    .way_o  (dec_way),
    .set_o  (dec_set),
    .tag_o  (dec_tag)
  );

  ocache_ctrl #(
    .WAYS(WAYS), .SET_W(SET_W), .TAG_W(TAG_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_fire_i  (cmd_fire),
    .op_i        (op_e'(cmd_op_i)),
    .dec_win_i   (dec_win),
    .dec_err_i   (dec_err),
    .dec_way_i   (dec_way),
    .dec_set_i   (dec_set),
    .dec_tag_i   (dec_tag),
    .lk_valid_i  (rd_valid),
    .lk_dirty_i  (rd_dirty),
    .lk_hit_i    (hit),
    .wb_ack_i    (wb_ack_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (addr_err_o),
    .wb_req_o    (wb_req_o),
    .set_o       (cur_set),
    .tag_o       (cur_tag),
    .wb_way_o    (wb_way),
    .upd_we_o    (upd_we),
    .upd_way_o   (upd_way),
    .upd_valid_o (upd_valid),
    .upd_dirty_o (upd_dirty)
  );

  ocache_tag_store #(
    .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)
  ) u_tags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_we_i    (fill_we),
    .fill_way_i   (fill_way_i),
    .fill_set_i   (fill_set_i),
    .fill_tag_i   (fill_tag_i),
    .fill_dirty_i (fill_dirty_i),
    .upd_we_i     (upd_we),
    .upd_way_i    (upd_way),
    .upd_set_i    (cur_set),
    .upd_valid_i  (upd_valid),
    .upd_dirty_i  (upd_dirty),
    .rd_set_i     (cur_set),
    .cmp_tag_i    (cur_tag),
    .rd_tag_o     (rd_tag),
    .rd_valid_o   (rd_valid),
    .rd_dirty_o   (rd_dirty),
    .hit_o        (hit)
  );

  ocache_data_store #(
    .WAYS(WAYS), .SETS(SETS), .LINE_W(LINE_W)
  ) u_data (
    .clk_i     (clk_i),
    .we_i      (fill_we),
    .wr_way_i  (fill_way_i),
    .wr_set_i  (fill_set_i),
    .wr_data_i (fill_data_i),
    .rd_way_i  (wb_way),
    .rd_set_i  (cur_set),
    .rd_data_o (wb_data_o)
  );

  assign wb_addr_o = {rd_tag[wb_way], cur_set, {OFF_W{1'b0}}};

  AST_WB_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_req_o && !wb_ack_i) |=> ($stable(wb_addr_o) && $stable(wb_data_o))); // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_err_o) |-> $past(busy_o)); // R7
endmodule

// File: tb/ocache_maint_test.sv
module ocache_maint_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [1:0]   cmd_op = '0;
  logic [31:0]  cmd_addr = '0;
  logic         cmd_priv = 1'b0;
  logic         busy, done, addr_err;
  logic         fill_valid = 1'b0;
  logic [1:0]   fill_way = '0;
  logic [7:0]   fill_set = '0;
  logic [18:0]  fill_tag = '0;
  logic         fill_dirty = 1'b0;
  logic [255:0] fill_data = '0;
  logic         wb_req;
  logic [31:0]  wb_addr;
  logic [255:0] wb_data;
  logic         wb_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  bit          mv [4][256];
  bit          md [4][256];
  logic [18:0] mt [4][256];

  always #4 clk = ~clk;

  ocache_maint uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_addr_i(cmd_addr), .cmd_priv_i(cmd_priv),
    .busy_o(busy), .done_o(done), .addr_err_o(addr_err),
    .fill_valid_i(fill_valid), .fill_way_i(fill_way), .fill_set_i(fill_set),
    .fill_tag_i(fill_tag), .fill_dirty_i(fill_dirty), .fill_data_i(fill_data),
    .wb_req_o(wb_req), .wb_addr_o(wb_addr), .wb_data_o(wb_data), .wb_ack_i(wb_ack)
  );

  function automatic logic [255:0] line_data(int w, int s, logic [18:0] t);
    return {8{{5'(w), 8'(s), t}}};
  endfunction

  function automatic logic [31:0] idx_addr(int w, int s);
    return {8'hF4, 9'h0, 2'(w), 8'(s), 5'h0};
  endfunction

  function automatic logic [18:0] mk_tag(int w, int k);
    return {2'(w), 17'(k)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic fill(input int w, input int s, input logic [18:0] t, input bit d);
    @(negedge clk);
    fill_valid = 1'b1; fill_way = 2'(w); fill_set = 8'(s);
    fill_tag = t; fill_dirty = d; fill_data = line_data(w, s, t);
    @(negedge clk);
    fill_valid = 1'b0;
    mv[w][s] = 1'b1; md[w][s] = d; mt[w][s] = t;
  endtask

  // cf*: fill in the issue cycle; inj: fill and command while waiting for ack
  task automatic do_cmd(input int op, input logic [31:0] addr, input bit priv, input int dly,
                        input string req, input bit cf, input int cw, input int cs,
                        input logic [18:0] ct, input bit inj, input logic [31:0] inj_addr);
    bit exp_wb, exp_err, got_err, seen, injd;
    logic [31:0]  exp_a, got_a;
    logic [255:0] exp_d, got_d;
    int reqc, cyc, s, w, hw;
    bit hitf;
    exp_wb = 0; exp_err = 0; exp_a = '0; exp_d = '0;
    s = int'(addr[12:5]);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_addr = addr; cmd_priv = priv;
    if (cf) begin
      fill_valid = 1'b1; fill_way = 2'(cw); fill_set = 8'(cs); fill_tag = ct;
      fill_dirty = 1'b1; fill_data = line_data(cw, cs, ct);
      mv[cw][cs] = 1'b1; md[cw][cs] = 1'b1; mt[cw][cs] = ct;
    end
    // expected outcome from the requirements
    if (op == 3) begin
      hitf = 0; hw = 0;
      for (int k = 3; k >= 0; k--) if (mv[k][s] && mt[k][s] == addr[31:13]) begin hitf = 1; hw = k; end
      if (hitf && md[hw][s]) begin
        exp_wb = 1; exp_a = {addr[31:13], 8'(s), 5'h0}; exp_d = line_data(hw, s, addr[31:13]);
        md[hw][s] = 0;
      end
    end else if (addr[31:24] == 8'hF4) begin
      if (!priv) exp_err = 1;
      else begin
        w = int'(addr[14:13]);
        if (mv[w][s] && md[w][s] && op != 0) begin
          exp_wb = 1; exp_a = {mt[w][s], 8'(s), 5'h0}; exp_d = line_data(w, s, mt[w][s]);
        end
        if (op != 2) mv[w][s] = 0;
        md[w][s] = 0;
      end
    end
    @(negedge clk);
    cmd_valid = 1'b0; fill_valid = 1'b0;
    chk(busy === 1'b1, "R2 busy after issue", 256'(busy), 256'(1));
    reqc = 0; cyc = 0; seen = 0; injd = 0; got_err = 0; got_a = '0; got_d = '0;
    while (1) begin
      if (done) begin got_err = addr_err; break; end
      if (wb_req) begin
        if (!seen) begin got_a = wb_addr; got_d = wb_data; seen = 1; end
        if (inj && !injd) begin
          injd = 1;
          fill_valid = 1'b1; fill_way = 2'd3; fill_set = 8'd250; fill_tag = mk_tag(3, 77);
          fill_dirty = 1'b1; fill_data = line_data(3, 250, mk_tag(3, 77));
          cmd_valid = 1'b1; cmd_op = 2'd3; cmd_addr = inj_addr; cmd_priv = 1'b1;
        end
        if (reqc == dly) wb_ack = 1'b1;
        reqc++;
      end
      @(negedge clk);
      wb_ack = 1'b0; fill_valid = 1'b0; cmd_valid = 1'b0;
      cyc++;
      if (cyc > 200) begin
        chk(0, "R2 completion timeout", 256'(cyc), 256'(0));
        break;
      end
    end
    chk(seen == exp_wb, {req, " write-back issued"}, 256'(seen), 256'(exp_wb));
    chk(got_err == exp_err, {req, " R7 address error"}, 256'(got_err), 256'(exp_err));
    if (exp_wb && seen) begin
      chk(got_a == exp_a, {req, " R10 wb address"}, 256'(got_a), 256'(exp_a));
      chk(got_d == exp_d, {req, " R10 wb data"}, got_d, exp_d);
      chk(reqc == dly + 1, "R10 request held until ack", 256'(reqc), 256'(dly + 1));
    end
    @(negedge clk);
    chk(!done && !busy && !addr_err, "R2 single done pulse then idle",
        256'({done, busy, addr_err}), 256'(0));
  endtask

  task automatic cmd(input int op, input logic [31:0] addr, input bit priv, input int dly, input string req);
    do_cmd(op, addr, priv, dly, req, 0, 0, 0, '0, 0, '0);
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "R2 watchdog expired", 256'(0), 256'(1));
    summary();
  end

  initial begin
    logic [18:0] t;
    int s;
    for (int w = 0; w < 4; w++) for (int k = 0; k < 256; k++) begin mv[w][k] = 0; md[w][k] = 0; mt[w][k] = '0; end
    repeat (3) @(negedge clk);
    chk({busy, done, addr_err, wb_req} === 4'b0, "R1 outputs in reset", 256'({busy, done, addr_err, wb_req}), 256'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, addr_err, wb_req} === 4'b0, "R1 outputs after reset", 256'({busy, done, addr_err, wb_req}), 256'(0));

    // R1: nothing valid or dirty after reset
    for (int w = 0; w < 4; w++) for (int k = 0; k < 4; k++) begin
      cmd(2, idx_addr(w, k * 85), 1, 0, "R1 indexed write-back on reset line");
      cmd(3, {mk_tag(w, k), 8'(k * 85), 5'h0}, 1, 0, "R1 flush on reset cache");
    end

    // R3..R7: indexed ops x privilege x dirty x way
    for (int op = 0; op < 3; op++) for (int p = 0; p < 2; p++)
      for (int d = 0; d < 2; d++) for (int w = 0; w < 4; w++) begin
        s = 16 + op * 32 + p * 16 + d * 8 + w * 2;
        t = mk_tag(w, s * 97 + op + 5);
        fill(w, s, t, d[0]);
        if (p == 0)       cmd(op, idx_addr(w, s), 1'b0, 0, "R7 user-mode indexed op");
        else if (op == 0) cmd(op, idx_addr(w, s), 1'b1, w % 3, "R4 indexed invalidate");
        else if (op == 1) cmd(op, idx_addr(w, s), 1'b1, w % 3, "R5 indexed purge");
        else              cmd(op, idx_addr(w, s), 1'b1, w % 3, "R6 indexed write-back");
        cmd(2, idx_addr(w, s), 1'b1, 0, "R3 probe by way and set");
      end

    // R8: addresses outside the 0xF4 window
    for (int hi = 8'hF0; hi <= 8'hFF; hi++) begin
      if (hi == 8'hF4) continue;
      s = 130 + (hi & 15);
      fill(hi & 3, s, mk_tag(hi & 3, hi), 1'b1);
      cmd(hi % 3, {8'(hi), 9'h0A5, 2'(hi & 3), 8'(s), 5'h3}, hi[0], 0, "R8 out-of-window op");
      cmd(2, idx_addr(hi & 3, s), 1'b1, 1, "R8 line untouched");
    end
    fill(1, 160, mk_tag(1, 9), 1'b1);
    cmd(1, {8'h12, 9'h0, 2'd1, 8'd160, 5'h0}, 1'b1, 0, "R8 ordinary address");
    cmd(2, idx_addr(1, 160), 1'b1, 0, "R8 line untouched");

    // R9: flush by physical tag
    for (int w = 0; w < 4; w++) fill(w, 200, mk_tag(w, w * 1111 + 7), w[0] ^ (w == 0));
    for (int w = 0; w < 4; w++) begin
      cmd(3, {mk_tag(w, w * 1111 + 7), 8'd200, 5'h1F}, w[0], w, "R9 flush lookup");
      cmd(3, {mk_tag(w, w * 1111 + 7), 8'd200, 5'h00}, 1'b1, 0, "R9 flush after clean");
    end
    cmd(3, {mk_tag(3, 17'h1ABCD), 8'd200, 5'h0}, 1'b0, 0, "R9 flush miss");
    cmd(2, idx_addr(3, 200), 1'b1, 0, "R9 line left valid after flush");

    // R12: fill and issue in the same cycle
    do_cmd(2, idx_addr(2, 230), 1'b1, 2, "R12 indexed with coincident fill",
           1, 2, 230, mk_tag(2, 4242), 0, '0);
    do_cmd(3, {mk_tag(1, 555), 8'd231, 5'h0}, 1'b1, 0, "R12 flush with coincident fill",
           1, 1, 231, mk_tag(1, 555), 0, '0);

    // R11 / R2: fill and command while busy are ignored
    fill(0, 240, mk_tag(0, 31), 1'b1);
    fill(1, 241, mk_tag(1, 32), 1'b1);
    do_cmd(1, idx_addr(0, 240), 1'b1, 3, "R5 purge with traffic while busy",
           0, 0, 0, '0, 1, {mk_tag(1, 32), 8'd241, 5'h0});
    cmd(2, idx_addr(3, 250), 1'b1, 0, "R11 fill while busy ignored");
    cmd(3, {mk_tag(1, 32), 8'd241, 5'h0}, 1'b1, 1, "R2 command while busy ignored");
    cmd(2, idx_addr(0, 240), 1'b1, 0, "R5 purged line gone");

    summary();
  end
endmodule